// File: doc/BRIEF.md
# Status Byte Service Request Controller

This block gathers the device's summary conditions into one 8-bit status byte and decides when to raise a service request toward the bus controller. Five condition lines come in live: the operation summary, the questionable summary, message available, error queue not empty and shutdown. An 8-bit event register catches one-cycle event pulses and holds them. Its own 8-bit enable mask reduces it to a single summary bit in the status byte.

A separate 8-bit service request mask chooses which status bits may request service. A request is latched only when an enabled bit newly rises, and never while the device is under local control. Bit 6 has two readings. The direct read output shows the master summary. The serial-poll output shows the request latch, and a poll strobe then drops the request. A clear-status command empties the event register and drops any pending request.

Top module: `sbsrq_top`

## Requirements
- R1: A synchronous active-high reset clears the event register, both enable masks, the request latch, the rise history and `srq`.
- R2: `stb_rd` bit positions are: 7 operation summary, 5 event summary, 4 message available, 3 questionable summary, 2 error queue not empty, 1 always 0, 0 shutdown. Bits 7, 4, 3, 2 and 0 follow their inputs in the same cycle.
- R3: Bit 5 of the status byte is the OR of the event register ANDed bitwise with the event enable mask. The event enable mask is loaded from `ese_wdata` on the clock edge where `ese_wr` is high.
- R4: On `stb_rd`, bit 6 is the OR of all other status bits ANDed with the request mask. The request mask is loaded from `sre_wdata` on the clock edge where `sre_wr` is high, with bit 6 stored as 0 whatever is written.
- R5: When any enabled status bit is high at a clock edge and was not high and enabled at the edge before, the request latch sets and `srq` is high after that edge. This includes a bit that was already high when its enable bit is written. An enabled bit that stays high does not set the latch again.
- R6: While `local_ctl` is high, `srq` is low. A rise seen during local control never sets the latch, and does not set it later either.
- R7: `poll_byte` equals `stb_rd` except that bit 6 is the request latch. A clock edge with `poll_strobe` high clears the latch unless a new rise sets it on that same edge. The master summary on `stb_rd` is left as it is.
- R8: Event register bits are sticky. A bit sets on the edge where its pulse is high. An edge with `esr_rd` high clears it, unless its pulse is high on that same edge.
- R9: An edge with `clr_status` high clears the whole event register and the request latch. This takes priority over same-cycle event pulses and rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| oper_sum | input | 1 | Operation register summary condition |
| ques_sum | input | 1 | Questionable register summary condition |
| msg_avail | input | 1 | Query response data available |
| errq_nonempty | input | 1 | Error/event queue holds an entry |
| shutdown | input | 1 | Power stage shut down |
| evt_pulse | input | 8 | One-cycle event pulses into the event register |
| esr_rd | input | 1 | Event register read strobe (clears it) |
| sre_wr | input | 1 | Request mask write strobe |
| sre_wdata | input | 8 | Request mask write value |
| ese_wr | input | 1 | Event enable mask write strobe |
| ese_wdata | input | 8 | Event enable mask write value |
| clr_status | input | 1 | Clear-status command |
| poll_strobe | input | 1 | Serial poll performed |
| local_ctl | input | 1 | Device is under local control |
| stb_rd | output | 8 | Status byte, direct-read view (bit 6 = master summary) |
| poll_byte | output | 8 | Status byte, serial-poll view (bit 6 = request service) |
| esr_q | output | 8 | Event register value |
| srq | output | 1 | Service request line |

## Verification
The properties assume that every control input is a clean, synchronous level for each whole cycle. They also assume reset is held for at least one edge before any other activity, so the checker's rise history starts from the same zero state as the design. The bench changes all inputs only at falling edges and starts every run inside reset. It exercises simultaneous strobes such as clear with pulse, read with pulse and poll with rise only in the combinations whose outcomes R7 to R9 define.

// File: rtl/sbsrq_pkg.sv
package sbsrq_pkg;

    localparam int STB_W = 8;
    localparam int EVT_W = 8;

    localparam int POS_SHUT = 0;
    localparam int POS_NONE = 1;
    localparam int POS_ERRQ = 2;
    localparam int POS_QUES = 3;
    localparam int POS_MAV  = 4;
    localparam int POS_ESB  = 5;
    localparam int POS_MSS  = 6;
    localparam int POS_OPER = 7;

    localparam logic [STB_W-1:0] MSS_BIT = STB_W'(1) << POS_MSS;

    typedef struct packed {
        logic oper;
        logic ques;
        logic mav;
        logic errq;
        logic shut;
    } cond_t;

    typedef enum logic [1:0] {
        REQ_HOLD  = 2'd0,
        REQ_SET   = 2'd1,
        REQ_DROP  = 2'd2
    } req_op_e;

    // Mask value as stored: the summary position cannot be enabled.
    function automatic logic [STB_W-1:0] sanitize_sre(input logic [STB_W-1:0] d);
        return d & ~MSS_BIT;
    endfunction

    // Status byte without the summary position.
    function automatic logic [STB_W-1:0] pack_status(input cond_t c, input logic esb);
        logic [STB_W-1:0] b;
        b           = '0;
        b[POS_OPER] = c.oper;
        b[POS_ESB]  = esb;
        b[POS_MAV]  = c.mav;
        b[POS_QUES] = c.ques;
        b[POS_ERRQ] = c.errq;
        b[POS_NONE] = 1'b0;
        b[POS_SHUT] = c.shut;
        return b;
    endfunction

endpackage

// File: rtl/sbsrq_event_reg.sv
module sbsrq_event_reg
    import sbsrq_pkg::*;
#(
    parameter int W = EVT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pulse,
    input  logic         rd,
    input  logic         clr,
    input  logic         en_wr,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] q,
    output logic         summary
);

    logic [W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else if (en_wr) en_q <= en_wdata;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clr)  q[i] <= 1'b0;
            else if (pulse[i]) q[i] <= 1'b1;
            else if (rd)     q[i] <= 1'b0;
        end
    end

    assign summary = |(q & en_q);

endmodule

// File: rtl/sbsrq_status_asm.sv
module sbsrq_status_asm
    import sbsrq_pkg::*;
(
    input  cond_t            cond,
    input  logic             esb,
    input  logic [STB_W-1:0] sre_q,
    output logic [STB_W-1:0] base,
    output logic [STB_W-1:0] masked,
    output logic             mss
);

    always_comb begin
        base   = pack_status(cond, esb);
        masked = base & sre_q & ~MSS_BIT;
        mss    = |masked;
    end

endmodule

// File: rtl/sbsrq_req_latch.sv
module sbsrq_req_latch
    import sbsrq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [STB_W-1:0] masked,
    input  logic             local_ctl,
    input  logic             poll,
    input  logic             clr,
    output logic             rqs
);

    logic [STB_W-1:0] hist_q;
    logic             rise;
    req_op_e          op;

    assign rise = |(masked & ~hist_q);

    always_comb begin
        if (clr)                     op = REQ_DROP;
        else if (rise && !local_ctl) op = REQ_SET;
        else if (poll)               op = REQ_DROP;
        else                         op = REQ_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            rqs    <= 1'b0;
        end else begin
            hist_q <= masked;
            case (op)
                REQ_SET:  rqs <= 1'b1;
                REQ_DROP: rqs <= 1'b0;
                default:  rqs <= rqs;
            endcase
        end
    end

endmodule

// File: rtl/sbsrq_top.sv
module sbsrq_top
    import sbsrq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       oper_sum,
    input  logic       ques_sum,
    input  logic       msg_avail,
    input  logic       errq_nonempty,
    input  logic       shutdown,
    input  logic [7:0] evt_pulse,
    input  logic       esr_rd,
    input  logic       sre_wr,
    input  logic [7:0] sre_wdata,
    input  logic       ese_wr,
    input  logic [7:0] ese_wdata,
    input  logic       clr_status,
    input  logic       poll_strobe,
    input  logic       local_ctl,
    output logic [7:0] stb_rd,
    output logic [7:0] poll_byte,
    output logic [7:0] esr_q,
    output logic       srq
);

    cond_t            cond;
    logic [STB_W-1:0] sre_q;
    logic [STB_W-1:0] base_w;
    logic [STB_W-1:0] masked_w;
    logic             mss_w;
    logic             esb_w;
    logic             rqs_w;

    assign cond = '{oper: oper_sum, ques: ques_sum, mav: msg_avail,
                    errq: errq_nonempty, shut: shutdown};

    always_ff @(posedge clk) begin
        if (rst) sre_q <= '0;
        else if (sre_wr) sre_q <= sanitize_sre(sre_wdata);
    end

    sbsrq_event_reg #(.W(EVT_W)) u_evt (
        .clk      (clk),
        .rst      (rst),
        .pulse    (evt_pulse),
        .rd       (esr_rd),
        .clr      (clr_status),
        .en_wr    (ese_wr),
        .en_wdata (ese_wdata),
        .q        (esr_q),
        .summary  (esb_w)
    );

    sbsrq_status_asm u_asm (
        .cond   (cond),
        .esb    (esb_w),
        .sre_q  (sre_q),
        .base   (base_w),
        .masked (masked_w),
        .mss    (mss_w)
    );

    sbsrq_req_latch u_req (
        .clk       (clk),
        .rst       (rst),
        .masked    (masked_w),
        .local_ctl (local_ctl),
        .poll      (poll_strobe),
        .clr       (clr_status),
        .rqs       (rqs_w)
    );

    always_comb begin
        stb_rd             = base_w;
        stb_rd[POS_MSS]    = mss_w;
        poll_byte          = base_w;
        poll_byte[POS_MSS] = rqs_w;
    end

    assign srq = rqs_w & ~local_ctl;

endmodule

// File: rtl/sbsrq_chk.sv
module sbsrq_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] masked,
    input logic       rqs,
    input logic       srq,
    input logic       local_ctl,
    input logic       poll_strobe,
    input logic       clr_status,
    input logic       esr_rd,
    input logic [7:0] esr_q
);

    logic [7:0] prev_m;
    logic       new_rise;

    always_ff @(posedge clk) begin
        if (rst) prev_m <= '0;
        else     prev_m <= masked;
    end

    assign new_rise = (masked & ~prev_m) != 8'h00;

    // R6
    a_r6_local_quiet: assert property (@(posedge clk) disable iff (rst)
        local_ctl |-> !srq);

    // R5
    a_r5_rise_sets: assert property (@(posedge clk) disable iff (rst)
        (new_rise && !local_ctl && !clr_status) |=> rqs);

    // R7
    a_r7_poll_drops: assert property (@(posedge clk) disable iff (rst)
        (poll_strobe && !clr_status && !(new_rise && !local_ctl)) |=> !rqs);

    // R9
    a_r9_clear_all: assert property (@(posedge clk) disable iff (rst)
        clr_status |=> (esr_q == 8'h00 && !rqs));

    // R8
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (!clr_status && !esr_rd) |=> ((esr_q & $past(esr_q)) == $past(esr_q)));

endmodule

bind sbsrq_top sbsrq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .masked      (masked_w),
    .rqs         (rqs_w),
    .srq         (srq),
    .local_ctl   (local_ctl),
    .poll_strobe (poll_strobe),
    .clr_status  (clr_status),
    .esr_rd      (esr_rd),
    .esr_q       (esr_q)
);

// File: tb/sim_sbsrq_top.sv
module sim_sbsrq_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       oper_sum = 0, ques_sum = 0, msg_avail = 0, errq_nonempty = 0, shutdown = 0;
    logic [7:0] evt_pulse = '0;
    logic       esr_rd = 0, sre_wr = 0, ese_wr = 0, clr_status = 0, poll_strobe = 0, local_ctl = 0;
    logic [7:0] sre_wdata = '0, ese_wdata = '0;
    logic [7:0] stb_rd, poll_byte, esr_q;
    logic       srq;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sbsrq_top u0 (
        .clk(clk), .rst(rst), .oper_sum(oper_sum), .ques_sum(ques_sum),
        .msg_avail(msg_avail), .errq_nonempty(errq_nonempty), .shutdown(shutdown),
        .evt_pulse(evt_pulse), .esr_rd(esr_rd), .sre_wr(sre_wr), .sre_wdata(sre_wdata),
        .ese_wr(ese_wr), .ese_wdata(ese_wdata), .clr_status(clr_status),
        .poll_strobe(poll_strobe), .local_ctl(local_ctl), .stb_rd(stb_rd),
        .poll_byte(poll_byte), .esr_q(esr_q), .srq(srq)
    );

    // {oper, ques, mav, errq, shut, sre[7:0], expected stb_rd[7:0]}
    localparam logic [20:0] VEC [7] = '{
        {5'b00000, 8'hFF, 8'h00},
        {5'b10000, 8'h00, 8'h80},
        {5'b10000, 8'h80, 8'hC0},
        {5'b00101, 8'h01, 8'h51},
        {5'b01010, 8'h40, 8'h0C},
        {5'b11111, 8'hFF, 8'hDD},
        {5'b00010, 8'h10, 8'h04}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_sre(input logic [7:0] d);
        sre_wr = 1; sre_wdata = d; tick(); sre_wr = 0;
    endtask

    task automatic write_ese(input logic [7:0] d);
        ese_wr = 1; ese_wdata = d; tick(); ese_wr = 0;
    endtask

    task automatic set_cond(input logic [4:0] c);
        {oper_sum, ques_sum, msg_avail, errq_nonempty, shutdown} = c;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk); tick(); tick();
        rst = 0;
        // R1 reset state
        chk("R1 stb", stb_rd, 8'h00);
        chk("R1 poll", poll_byte, 8'h00);
        chk("R1 esr", esr_q, 8'h00);
        chk("R1 srq", {7'd0, srq}, 8'h00);

        // R2 / R4 table walk
        for (int k = 0; k < 7; k++) begin
            set_cond(VEC[k][20:16]);
            write_sre(VEC[k][15:8]);
            chk("R2 R4 table", stb_rd, VEC[k][7:0]);
        end

        set_cond(5'b00000);
        write_sre(8'h00);
        clr_status = 1; tick(); clr_status = 0;
        chk("R9 srq after clear", {7'd0, srq}, 8'h00);

        // R5 rise sets request
        write_sre(8'h04);
        errq_nonempty = 1; tick();
        chk("R5 srq on rise", {7'd0, srq}, 8'h01);
        chk("R7 poll bit6", poll_byte, 8'h44);
        tick();
        chk("R5 srq held", {7'd0, srq}, 8'h01);
        // R7 poll drops request, summary stays
        poll_strobe = 1; tick(); poll_strobe = 0;
        chk("R7 srq after poll", {7'd0, srq}, 8'h00);
        chk("R7 mss kept", stb_rd, 8'h44);
        chk("R7 poll view", poll_byte, 8'h04);
        tick();
        chk("R5 no retrigger", {7'd0, srq}, 8'h00);

        // R6 local control
        errq_nonempty = 0; tick();
        local_ctl = 1;
        errq_nonempty = 1; tick();
        chk("R6 srq in local", {7'd0, srq}, 8'h00);
        chk("R6 latch in local", poll_byte, 8'h04);
        local_ctl = 0; tick();
        chk("R6 no late request", {7'd0, srq}, 8'h00);

        // R5 enable written while bit high
        errq_nonempty = 0;
        oper_sum = 1;
        write_sre(8'h00);
        tick();
        write_sre(8'h80);
        chk("R5 enable edge", {7'd0, srq}, 8'h00);
        tick();
        chk("R5 enable later", {7'd0, srq}, 8'h01);
        // R6 gating of a latched request
        local_ctl = 1; tick();
        chk("R6 latched gated", {7'd0, srq}, 8'h00);
        local_ctl = 0; tick();
        chk("R6 latched release", {7'd0, srq}, 8'h01);
        poll_strobe = 1; tick(); poll_strobe = 0;
        oper_sum = 0;
        write_sre(8'h00);

        // R3 / R8 event register
        write_ese(8'h00);
        evt_pulse = 8'h21; tick(); evt_pulse = 8'h00;
        chk("R8 set", esr_q, 8'h21);
        chk("R3 esb masked", stb_rd, 8'h00);
        write_ese(8'h20);
        chk("R3 esb on", stb_rd, 8'h20);
        evt_pulse = 8'h02; tick(); evt_pulse = 8'h00;
        chk("R8 sticky", esr_q, 8'h23);
        esr_rd = 1; evt_pulse = 8'h80; tick(); esr_rd = 0; evt_pulse = 8'h00;
        chk("R8 read keeps new pulse", esr_q, 8'h80);
        esr_rd = 1; tick(); esr_rd = 0;
        chk("R8 read clears", esr_q, 8'h00);

        // R5 via event summary, then R9 clear
        write_sre(8'h20);
        evt_pulse = 8'h20; tick(); evt_pulse = 8'h00;
        chk("R3 esb rises", stb_rd, 8'h60);
        tick();
        chk("R5 srq from esb", {7'd0, srq}, 8'h01);
        clr_status = 1; evt_pulse = 8'h04; tick(); clr_status = 0; evt_pulse = 8'h00;
        chk("R9 esr cleared", esr_q, 8'h00);
        chk("R9 srq cleared", {7'd0, srq}, 8'h00);

        // R1 reset mid-run
        evt_pulse = 8'h10; tick(); evt_pulse = 8'h00;
        shutdown = 1;
        rst = 1; tick(); rst = 0;
        chk("R1 esr reset", esr_q, 8'h00);
        chk("R1 mask reset", stb_rd, 8'h01);
        chk("R1 srq reset", {7'd0, srq}, 8'h00);

        finish_run();
    end

endmodule